// File: doc/BRIEF.md
# Companion I/O System Register Block

This block is the system configuration register file of a companion I/O device, reached over a simple byte-wide read/write bus. It holds two groups of state. The first is a 16-pin general-purpose output port, whose data values and output-enable values are each written through three byte-wide lanes. The second is an 8-source interrupt status and mask pair that drives one combined interrupt line to the host. A constant revision byte and a routing byte with no other effect complete the map.

Each pin drives the AND of its data bit and its enable bit. Whenever a data or enable write changes that driven value on some pins, the block raises a one-cycle change strobe on exactly those pins, alongside the new levels. A pin that has been disabled can have its data byte rewritten without any visible effect. Sub-interrupt inputs set sticky status bits. Software clears them by writing ones to the status byte, and the host line is raised while any unmasked status bit is set.

Top module: `ioc_sysreg`

## Requirements
- R1: After a synchronous active-low reset, every readable register except the revision byte reads 0x00, `pin_level` is 0, `pin_chg` is 0 and `host_irq` is 0.
- R2: Offset 0x08 reads the constant `REV_ID` (default 0x03). Writes to it have no effect.
- R3: Output data lanes sit at offsets 0x78, 0x79 and 0x7A. Lane n holds data bits 8n+7..8n. A write replaces only the addressed lane, and a read returns the stored byte of that lane.
- R4: Output-enable lanes sit at offsets 0x7C, 0x7D and 0x7E, with the same lane-to-bit mapping, write isolation and readback as R3.
- R5: From the cycle after a write, `pin_level[i]` equals data bit i AND enable bit i for pins 15..0. Lane 2 is stored and read back but drives no pin.
- R6: In the cycle after a data or enable write, `pin_chg[i]` is 1 exactly when the new driven level of pin i differs from the level it had before. In every other cycle `pin_chg` is 0.
- R7: A sub-interrupt input `irq_src[i]` that is high at a clock edge sets status bit i, read at offset 0x50. The sources are numbered flash controller = 0, card interface = 1, USB host = 2, serial = 3, display = 4; 5..7 are spare.
- R8: Writing 0x50 clears each status bit written as 1 and keeps each bit written as 0. A source that is high in the same cycle as the clear keeps its bit set.
- R9: The mask byte at offset 0x52 is read/write. `host_irq` is 1 exactly when (status AND mask) is nonzero, and it follows register changes in the cycle after the edge.
- R10: The routing byte at offset 0x54 is read/write and affects no output.
- R11: Reads of any unmapped offset return 0x00, and writes to unmapped offsets change no register or output. `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read enable |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| irq_src | input | 8 | Sub-interrupt inputs, active high |
| host_irq | output | 1 | Combined host interrupt |
| pin_level | output | 16 | Driven level of each output pin |
| pin_chg | output | 16 | One-cycle strobe per pin whose driven level changed |

## Verification
The hardest situations to reach from the ports are writes that change a stored byte but not the driven level. Examples are rewriting the data of a disabled pin, enabling a pin whose data is zero, and any write to lane 2. A naive design would strobe on these writes. The stimulus first builds random enable patterns with partial lanes and then fires random data and enable writes across all six lanes, so many writes leave the driven level unchanged. The bench also sets up a status clear on the same edge as a rising source, to reach the case where the set must win.

// File: rtl/ioc_sysreg_pkg.sv
// Package: offsets and sizes shared by the system register block.
// Assumes an 8-bit byte offset bus; all lanes are one byte wide.
package ioc_sysreg_pkg;
    localparam int ADDR_W  = 8;
    localparam int BYTE_W  = 8;
    localparam int PINS    = 16;
    localparam int LANES   = 3;
    localparam int SRC_N   = 8;

    localparam logic [ADDR_W-1:0] OFS_REV    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h52;
    localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_DAT0   = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_OE0    = 8'h7C;

    // Sub-interrupt source numbering
    localparam int SRC_FLASH   = 0;
    localparam int SRC_CARD    = 1;
    localparam int SRC_USBH    = 2;
    localparam int SRC_SERIAL  = 3;
    localparam int SRC_DISPLAY = 4;
endpackage

// File: rtl/ioc_gpio_out.sv
// Module: output port with lane-written data and enable registers.
// Drives data AND enable per pin and strobes the pins whose driven
// level changes on a write. Assumes at most one lane written per cycle
// per register and PINS <= LANES*BYTE_W.
module ioc_gpio_out #(
    parameter int PINS   = 16,
    parameter int LANES  = 3,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        dat_we,
    input  logic [LANES-1:0]        oe_we,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [LANES*BYTE_W-1:0] dat_q,
    output logic [LANES*BYTE_W-1:0] oe_q,
    output logic [PINS-1:0]         pin_level,
    output logic [PINS-1:0]         pin_chg
);
    localparam int STORE_W = LANES * BYTE_W;

    logic [STORE_W-1:0] dat_n;
    logic [STORE_W-1:0] oe_n;
    logic [PINS-1:0]    eff_n;
    logic               any_we;

    // Next-state values with the addressed lane replaced.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dat_n[l*BYTE_W +: BYTE_W] = dat_we[l] ? wdata : dat_q[l*BYTE_W +: BYTE_W];
        assign oe_n[l*BYTE_W +: BYTE_W]  = oe_we[l]  ? wdata : oe_q[l*BYTE_W +: BYTE_W];
    end

    assign eff_n  = dat_n[PINS-1:0] & oe_n[PINS-1:0];
    assign any_we = |{dat_we, oe_we};

    // Lane storage for data and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            oe_q  <= '0;
        end else begin
            dat_q <= dat_n;
            oe_q  <= oe_n;
        end
    end

    // Recorded driven level and per-pin change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_level <= '0;
            pin_chg   <= '0;
        end else if (any_we) begin
            pin_level <= eff_n;
            pin_chg   <= eff_n ^ pin_level;
        end else begin
            pin_chg   <= '0;
        end
    end

    // R6
    chg_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_chg) |-> ((pin_level ^ $past(pin_level)) == pin_chg));

    // R6
    no_write_no_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_we |=> (pin_chg == '0));

    // R3
    dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we == '0) |=> $stable(dat_q));

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_we == '0) |=> $stable(oe_q));

    // R5
    level_within_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & ~oe_q[PINS-1:0]) == '0);
endmodule

// File: rtl/ioc_irq_ctl.sv
// Module: sticky interrupt status with write-one-to-clear and a mask.
// A source high at an edge sets its bit; a set beats a clear in the
// same cycle. Host line is the OR of unmasked status bits.
module ioc_irq_ctl #(
    parameter int SRC_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [SRC_N-1:0] wdata,
    output logic [SRC_N-1:0] status_q,
    output logic [SRC_N-1:0] mask_q,
    output logic             host_irq
);
    logic [SRC_N-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    // Status bits: clear on written ones, then set by live sources.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | src;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Combined host interrupt.
    assign host_irq = |(status_q & mask_q);

    // R7
    src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src) |=> ((status_q & $past(src)) == $past(src)));

    // R8
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_bits & ~src)) |=> ((status_q & $past(clr_bits & ~src)) == '0));
endmodule

// File: rtl/ioc_sysreg.sv
// Module: top of the system register block. Decodes the byte bus,
// muxes read data and hosts the output port and interrupt units.
// Assumes single-byte accesses; reads are combinational and free of
// side effects.
module ioc_sysreg
    import ioc_sysreg_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  irq_src,
    output logic              host_irq,
    output logic [PINS-1:0]   pin_level,
    output logic [PINS-1:0]   pin_chg
);
    localparam int STORE_W = LANES * BYTE_W;

    logic [LANES-1:0]   dat_we;
    logic [LANES-1:0]   oe_we;
    logic [STORE_W-1:0] dat_q;
    logic [STORE_W-1:0] oe_q;
    logic [SRC_N-1:0]   status_q;
    logic [SRC_N-1:0]   mask_q;
    logic [BYTE_W-1:0]  route_q;
    logic               clr_we;
    logic               mask_we;
    logic [BYTE_W-1:0]  rd_val;

    // Lane write decode.
    for (genvar l = 0; l < LANES; l++) begin : g_dec
        assign dat_we[l] = bus_wr && (bus_addr == OFS_DAT0 + ADDR_W'(l));
        assign oe_we[l]  = bus_wr && (bus_addr == OFS_OE0 + ADDR_W'(l));
    end
    assign clr_we  = bus_wr && (bus_addr == OFS_STAT);
    assign mask_we = bus_wr && (bus_addr == OFS_MASK);

    // Routing byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                               route_q <= '0;
        else if (bus_wr && bus_addr == OFS_ROUTE) route_q <= bus_wdata;
    end

    // Read data mux; unmapped offsets read zero.
    always_comb begin
        rd_val = '0;
        if (bus_addr == OFS_REV)   rd_val = REV_ID;
        if (bus_addr == OFS_STAT)  rd_val = BYTE_W'(status_q);
        if (bus_addr == OFS_MASK)  rd_val = BYTE_W'(mask_q);
        if (bus_addr == OFS_ROUTE) rd_val = route_q;
        for (int l = 0; l < LANES; l++) begin
            if (bus_addr == OFS_DAT0 + ADDR_W'(l)) rd_val = dat_q[l*BYTE_W +: BYTE_W];
            if (bus_addr == OFS_OE0 + ADDR_W'(l))  rd_val = oe_q[l*BYTE_W +: BYTE_W];
        end
    end
    assign bus_rdata = bus_rd ? rd_val : '0;

    ioc_gpio_out #(.PINS(PINS), .LANES(LANES), .BYTE_W(BYTE_W)) u_gpio (
        .clk       (clk),
        .rst_n     (rst_n),
        .dat_we    (dat_we),
        .oe_we     (oe_we),
        .wdata     (bus_wdata),
        .dat_q     (dat_q),
        .oe_q      (oe_q),
        .pin_level (pin_level),
        .pin_chg   (pin_chg)
    );

    ioc_irq_ctl #(.SRC_N(SRC_N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_src),
        .clr_we   (clr_we),
        .mask_we  (mask_we),
        .wdata    (bus_wdata[SRC_N-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .host_irq (host_irq)
    );

    // R10
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_ROUTE) |=> $stable(route_q));
endmodule

// File: tb/ioc_sysreg_tb.sv
// Bench: directed corners plus seeded random writes, checked against a
// byte-level model kept in the bench.
module ioc_sysreg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  irq_src = 8'h00;
    logic        host_irq;
    logic [15:0] pin_level;
    logic [15:0] pin_chg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_dat [3];
    logic [7:0] m_oe  [3];
    logic [7:0] m_stat, m_mask, m_route;
    logic [15:0] m_lvl;

    always #5 clk = ~clk;

    ioc_sysreg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .host_irq(host_irq),
        .pin_level(pin_level), .pin_chg(pin_chg)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] eff();
        return {m_dat[1], m_dat[0]} & {m_oe[1], m_oe[0]};
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        case (a)
            8'h08: return 8'h03;
            8'h50: return m_stat;
            8'h52: return m_mask;
            8'h54: return m_route;
            8'h78, 8'h79, 8'h7A: return m_dat[a - 8'h78];
            8'h7C, 8'h7D, 8'h7E: return m_oe[a - 8'h7C];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h08: return "R2";
            8'h50: return "R8";
            8'h52: return "R9";
            8'h54: return "R10";
            8'h78, 8'h79, 8'h7A: return "R3";
            8'h7C, 8'h7D, 8'h7E: return "R4";
            default: return "R11";
        endcase
    endfunction

    // Bus write with optional simultaneous source; checks pins and irq.
    task automatic wr(logic [7:0] a, logic [7:0] d, logic [7:0] src);
        logic [15:0] old_lvl;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; irq_src = src;
        @(posedge clk);
        old_lvl = m_lvl;
        case (a)
            8'h50: m_stat = m_stat & ~d;
            8'h52: m_mask = d;
            8'h54: m_route = d;
            8'h78, 8'h79, 8'h7A: m_dat[a - 8'h78] = d;
            8'h7C, 8'h7D, 8'h7E: m_oe[a - 8'h7C] = d;
            default: ;
        endcase
        m_stat = m_stat | src;
        m_lvl = eff();
        @(negedge clk);
        bus_wr = 1'b0; irq_src = 8'h00;
        chk(pin_level == m_lvl, "R5 level", 32'(pin_level), 32'(m_lvl));
        if (a inside {8'h78, 8'h79, 8'h7A, 8'h7C, 8'h7D, 8'h7E})
            chk(pin_chg == (old_lvl ^ m_lvl), "R6 strobe", 32'(pin_chg), 32'(old_lvl ^ m_lvl));
        else
            chk(pin_chg == 16'h0, "R11 no strobe", 32'(pin_chg), 32'h0);
        chk(host_irq == |(m_stat & m_mask), "R9 host_irq", 32'(host_irq), 32'(|(m_stat & m_mask)));
    endtask

    task automatic rd(logic [7:0] a);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        chk(bus_rdata == exp_rd(a), tag_of(a), 32'(bus_rdata), 32'(exp_rd(a)));
        bus_rd = 1'b0;
        #1;
        chk(bus_rdata == 8'h00, "R11 rd low", 32'(bus_rdata), 32'h0);
    endtask

    task automatic pulse(logic [7:0] src);
        @(negedge clk);
        irq_src = src;
        @(negedge clk);
        irq_src = 8'h00;
        m_stat = m_stat | src;
        chk(host_irq == |(m_stat & m_mask), "R7 set", 32'(host_irq), 32'(|(m_stat & m_mask)));
        rd(8'h50);
    endtask

    function automatic logic [7:0] pick_addr(int unsigned r);
        case (r % 12)
            0: return 8'h78; 1: return 8'h79; 2: return 8'h7A;
            3: return 8'h7C; 4: return 8'h7D; 5: return 8'h7E;
            6: return 8'h50; 7: return 8'h52; 8: return 8'h54;
            9: return 8'h08;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin m_dat[i] = 8'h0; m_oe[i] = 8'h0; end
        m_stat = 8'h0; m_mask = 8'h0; m_route = 8'h0; m_lvl = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pin_level == 16'h0, "R1 pin_level", 32'(pin_level), 32'h0);
        chk(pin_chg == 16'h0, "R1 pin_chg", 32'(pin_chg), 32'h0);
        chk(host_irq == 1'b0, "R1 host_irq", 32'(host_irq), 32'h0);
        rd(8'h08); rd(8'h50); rd(8'h52); rd(8'h54);
        for (int i = 0; i < 3; i++) begin rd(8'h78 + 8'(i)); rd(8'h7C + 8'(i)); end

        // R2 revision is read-only
        wr(8'h08, 8'hFF, 8'h00); rd(8'h08);
        // R5/R6: data on disabled pins does nothing, enable then shows it
        wr(8'h78, 8'hA5, 8'h00);
        wr(8'h7C, 8'h0F, 8'h00);
        wr(8'h7D, 8'hFF, 8'h00);
        wr(8'h79, 8'h3C, 8'h00);
        // lane 2 drives no pin (R5)
        wr(8'h7A, 8'hFF, 8'h00);
        wr(8'h7E, 8'hFF, 8'h00);
        rd(8'h7A); rd(8'h7E);
        // R6: strobe is only one cycle
        @(negedge clk);
        chk(pin_chg == 16'h0, "R6 one cycle", 32'(pin_chg), 32'h0);
        // R11 unmapped write ignored
        wr(8'h79 + 8'h02, 8'h00, 8'h00);
        wr(8'hC3, 8'hFF, 8'h00); rd(8'hC3); rd(8'h7B);
        // R7/R9 sources and mask
        pulse(8'h01 << 0);
        pulse(8'h01 << 4);
        wr(8'h52, 8'h10, 8'h00);
        wr(8'h50, 8'h10, 8'h00);
        pulse(8'h08);
        wr(8'h52, 8'h08, 8'h00);
        // R8 clear with set on same edge: set wins for bit 3
        wr(8'h50, 8'hFF, 8'h08);
        rd(8'h50);
        wr(8'h50, 8'h08, 8'h00);
        rd(8'h50);
        // R10 routing byte
        wr(8'h54, 8'h5A, 8'h00); rd(8'h54);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = pick_addr($urandom);
            if (($urandom % 8) == 0) pulse(8'($urandom));
            else wr(a, 8'($urandom), (($urandom % 5) == 0) ? 8'($urandom) : 8'h00);
            rd(pick_addr($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule